// File: doc/BRIEF.md
# Dual-Chain Serial Configuration Front End for a 16-Channel LED Sink Driver

This block takes one serial port (data in, shift clock, latch strobe, data out) and a chain-select input, and uses them to program two separate settings for sixteen LED channels. The port is time-shared. With the select low it reaches a 16-bit chain whose held value gives each channel an on/off enable. With the select high it reaches a 112-bit chain whose held value gives each channel a 7-bit brightness code. Each chain has a bank of holding registers behind it. A latch strobe copies the selected chain into its bank and leaves the other bank untouched.

In on/off mode, the strobe also reloads the on/off chain with a 16-bit open-LED status vector, right after the copy. A host that shifts in the next on/off word therefore reads back the per-channel status on the serial output at the same time. All port inputs are sampled on the system clock through a two-stage synchronizer. Rising edges of the shift clock and strobe are detected after synchronization.

A four-state controller sequences the strobe. In ST_IDLE, shifting is allowed while the strobe is low. A strobe rising edge moves it to ST_XFER, where the selected bank is written. From ST_XFER it goes to ST_SNAP when the select is low, or to ST_HOLD when the select is high. ST_SNAP loads the status vector into the on/off chain and always moves on to ST_HOLD. ST_HOLD waits for the strobe to fall, then returns to ST_IDLE. No shifting happens outside ST_IDLE.

Top module: `led_cfg_front`

## Requirements
- R1: After reset, every enable bit, every brightness code and the serial output are zero.
- R2: With the select low, each detected shift-clock rise shifts the 16-bit chain by one. A strobe rise then sets chan_en to the 16 bits shifted in. The first bit sent lands in channel 15 and the last bit sent lands in channel 0.
- R3: With the select high, 112 shifts followed by a strobe set chan_level. Channel c occupies bits 7c+6 down to 7c, with bit 7c+6 as the MSB. The word is sent from bit 111 down to bit 0, so channel 15's MSB goes first.
- R4: A strobe updates only the bank of the selected chain. The bank of the other chain keeps its value.
- R5: ser_out presents the last stage of the chain named by the current select value. That is stage 15 of the on/off chain, or stage 111 of the brightness chain.
- R6: A strobe with the select low loads open_status into the on/off chain, bit i into stage i. ser_out then shows open_status[15], and each following shift reveals the next lower bit. A strobe with the select high loads no status.
- R7: Shift-clock rises that arrive while the strobe is high do not move either chain.
- R8: Shifting alone never changes chan_en or chan_level.
- R9: A bit entering the brightness chain reaches ser_out after exactly 112 shifts. The bit that entered next follows after one more shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_bright | input | 1 | Chain select: 0 = on/off chain, 1 = brightness chain |
| ser_in | input | 1 | Serial data in |
| ser_clk | input | 1 | Serial shift clock (rising edge shifts) |
| ser_lat | input | 1 | Latch strobe (rising edge transfers) |
| open_status | input | 16 | Per-channel open-LED status for readback |
| ser_out | output | 1 | Serial data out, last stage of the selected chain |
| chan_en | output | 16 | Held per-channel enables |
| chan_level | output | 112 | Held 7-bit brightness codes, channel c at bits 7c+6:7c |

## Verification
The assertions take three things for granted about the inputs. Each serial input stays stable for several system clocks, so the synchronized data and the synchronized shift-clock edge line up. The select does not change while the strobe is high. Data is shifted only while the strobe is low. The stimulus tasks meet these assumptions in the following way. Data and select are set a few clocks before a shift-clock rise and held for several clocks after it. The select is changed only with the strobe low, followed by a settling wait. The strobe is held high long enough for the transfer and the status load to finish. Shift pulses are placed inside a strobe-high window only in the scenario that checks that they are ignored.

// File: rtl/lcfg_pkg.sv
package lcfg_pkg;
    localparam int unsigned N_CH       = 16;
    localparam int unsigned CODE_W     = 7;
    localparam int unsigned BRI_W      = N_CH * CODE_W;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_SNAP,
        ST_HOLD
    } xfer_st_e;
endpackage

// File: rtl/lcfg_in_sync.sv
module lcfg_in_sync #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stg [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[k] <= '0;
                else        stg[k] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[k] <= '0;
                else        stg[k] <= stg[k-1];
            end
        end
    end

    assign q_out = stg[DEPTH-1];
endmodule

// File: rtl/lcfg_edge.sv
module lcfg_edge #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/lcfg_chain.sv
module lcfg_chain #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             ser_d,
    input  logic             xfer_en,
    input  logic             snap_en,
    input  logic [WIDTH-1:0] snap_d,
    output logic [WIDTH-1:0] sr_q,
    output logic [WIDTH-1:0] hold_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            hold_q <= '0;
        end else begin
            if (snap_en)       sr_q <= snap_d;
            else if (shift_en) sr_q <= {sr_q[WIDTH-2:0], ser_d};
            if (xfer_en)       hold_q <= sr_q;
        end
    end
endmodule

// File: rtl/lcfg_fsm.sv
module lcfg_fsm
    import lcfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     lat_lvl,
    input  logic     lat_rise,
    input  logic     clk_rise,
    input  logic     mode_lvl,
    output xfer_st_e st,
    output logic     shift_onoff,
    output logic     shift_bri,
    output logic     xfer_onoff,
    output logic     xfer_bri,
    output logic     snap_onoff
);
    xfer_st_e st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (lat_rise) st_nx = ST_XFER;
            ST_XFER: st_nx = mode_lvl ? ST_HOLD : ST_SNAP;
            ST_SNAP: st_nx = ST_HOLD;
            ST_HOLD: if (!lat_lvl) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        shift_onoff = 1'b0;
        shift_bri   = 1'b0;
        xfer_onoff  = 1'b0;
        xfer_bri    = 1'b0;
        snap_onoff  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                shift_onoff = clk_rise && !lat_lvl && !mode_lvl;
                shift_bri   = clk_rise && !lat_lvl && mode_lvl;
            end
            ST_XFER: begin
                xfer_onoff = !mode_lvl;
                xfer_bri   = mode_lvl;
            end
            ST_SNAP: snap_onoff = 1'b1;
            ST_HOLD: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/led_cfg_front.sv
module led_cfg_front
    import lcfg_pkg::*;
#(
    parameter int unsigned NUM_CH  = N_CH,
    parameter int unsigned LEVEL_W = CODE_W,
    parameter int unsigned SYNC_N  = SYNC_DEPTH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sel_bright,
    input  logic                        ser_in,
    input  logic                        ser_clk,
    input  logic                        ser_lat,
    input  logic [NUM_CH-1:0]           open_status,
    output logic                        ser_out,
    output logic [NUM_CH-1:0]           chan_en,
    output logic [NUM_CH*LEVEL_W-1:0]   chan_level
);
    localparam int unsigned LVL_BITS = NUM_CH * LEVEL_W;

    logic [3:0] raw_in, syn_in;
    logic       mode_s, sin_s, sclk_s, lat_s;
    logic [1:0] rise_v;
    logic       clk_rise, lat_rise;
    logic       shift_onoff, shift_bri, xfer_onoff, xfer_bri, snap_onoff;
    xfer_st_e   st;
    logic [NUM_CH-1:0]   en_sr;
    logic [LVL_BITS-1:0] bri_sr;

    assign raw_in = {sel_bright, ser_in, ser_clk, ser_lat};

    lcfg_in_sync #(.WIDTH(4), .DEPTH(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(raw_in), .q_out(syn_in)
    );

    assign {mode_s, sin_s, sclk_s, lat_s} = syn_in;

    lcfg_edge #(.WIDTH(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl({sclk_s, lat_s}), .rise(rise_v)
    );

    assign {clk_rise, lat_rise} = rise_v;

    lcfg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .lat_lvl(lat_s), .lat_rise(lat_rise), .clk_rise(clk_rise),
        .mode_lvl(mode_s), .st(st),
        .shift_onoff(shift_onoff), .shift_bri(shift_bri),
        .xfer_onoff(xfer_onoff), .xfer_bri(xfer_bri),
        .snap_onoff(snap_onoff)
    );

    lcfg_chain #(.WIDTH(NUM_CH)) u_onoff (
        .clk(clk), .rst_n(rst_n),
        .shift_en(shift_onoff), .ser_d(sin_s),
        .xfer_en(xfer_onoff), .snap_en(snap_onoff), .snap_d(open_status),
        .sr_q(en_sr), .hold_q(chan_en)
    );

    lcfg_chain #(.WIDTH(LVL_BITS)) u_bright (
        .clk(clk), .rst_n(rst_n),
        .shift_en(shift_bri), .ser_d(sin_s),
        .xfer_en(xfer_bri), .snap_en(1'b0), .snap_d({LVL_BITS{1'b0}}),
        .sr_q(bri_sr), .hold_q(chan_level)
    );

    assign ser_out = mode_s ? bri_sr[LVL_BITS-1] : en_sr[NUM_CH-1];
endmodule

// File: rtl/led_cfg_front_chk.sv
module led_cfg_front_chk
    import lcfg_pkg::*;
#(
    parameter int unsigned NUM_CH   = N_CH,
    parameter int unsigned LVL_BITS = BRI_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mode_s,
    input logic                lat_s,
    input logic                lat_rise,
    input xfer_st_e            st,
    input logic [NUM_CH-1:0]   open_status,
    input logic [NUM_CH-1:0]   en_sr,
    input logic [LVL_BITS-1:0] bri_sr,
    input logic                ser_out,
    input logic [NUM_CH-1:0]   chan_en,
    input logic [LVL_BITS-1:0] chan_level
);
    p_xfer_follows_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && lat_rise) |=> (st == ST_XFER));

    p_en_only_on_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_en) |-> $past(st == ST_XFER && !mode_s));

    p_level_only_on_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_level) |-> $past(st == ST_XFER && mode_s));

    p_status_loaded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SNAP) |=> (en_sr == $past(open_status)));

    p_status_on_sout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SNAP) |=> (mode_s || ser_out == $past(open_status[NUM_CH-1])));

    p_no_shift_strobe_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lat_s |=> $stable(bri_sr));
endmodule

bind led_cfg_front led_cfg_front_chk #(.NUM_CH(NUM_CH), .LVL_BITS(LVL_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_s(mode_s), .lat_s(lat_s),
    .lat_rise(lat_rise), .st(st), .open_status(open_status),
    .en_sr(en_sr), .bri_sr(bri_sr), .ser_out(ser_out),
    .chan_en(chan_en), .chan_level(chan_level)
);

// File: tb/tb_led_cfg_front.sv
module tb_led_cfg_front;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int LW  = 112;

    logic clk, rst_n, sel_bright, ser_in, ser_clk, ser_lat;
    logic [NCH-1:0] open_status;
    logic           ser_out;
    logic [NCH-1:0] chan_en;
    logic [LW-1:0]  chan_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    led_cfg_front dut (
        .clk(clk), .rst_n(rst_n), .sel_bright(sel_bright), .ser_in(ser_in),
        .ser_clk(ser_clk), .ser_lat(ser_lat), .open_status(open_status),
        .ser_out(ser_out), .chan_en(chan_en), .chan_level(chan_level)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_in = b;
        wait_clk(3);
        ser_clk = 1'b1;
        wait_clk(4);
        ser_clk = 1'b0;
        wait_clk(3);
    endtask

    task automatic strobe();
        ser_lat = 1'b1;
        wait_clk(8);
        ser_lat = 1'b0;
        wait_clk(6);
    endtask

    task automatic set_mode(input logic m);
        sel_bright = m;
        wait_clk(6);
    endtask

    function automatic logic [LW-1:0] make_levels(input int seed);
        logic [LW-1:0] w;
        w = '0;
        for (int c = 0; c < NCH; c++) w[c*7 +: 7] = 7'((c * 37 + seed) & 127);
        return w;
    endfunction

    task automatic t_reset();
        chk("R1 chan_en after reset", 128'(chan_en), 128'h0);
        chk("R1 chan_level after reset", 128'(chan_level), 128'h0);
        chk("R1 ser_out after reset", 128'(ser_out), 128'h0);
    endtask

    task automatic t_onoff();
        logic [NCH-1:0] pat1, pat2, st1;
        pat1 = 16'hA5C3;
        pat2 = 16'h0F3C;
        st1  = 16'h9234;
        set_mode(1'b0);
        for (int i = NCH-1; i >= 0; i--) send_bit(pat1[i]);
        chk("R8 chan_en unchanged by shifting", 128'(chan_en), 128'h0);
        chk("R5 ser_out shows first bit sent", 128'(ser_out), 128'(pat1[15]));
        open_status = st1;
        strobe();
        chk("R2 chan_en after on/off load", 128'(chan_en), 128'(pat1));
        chk("R4 chan_level untouched by on/off strobe", 128'(chan_level), 128'h0);
        for (int i = NCH-1; i >= 0; i--) begin
            chk($sformatf("R6 status bit %0d on ser_out", i), 128'(ser_out), 128'(st1[i]));
            send_bit(pat2[i]);
        end
        open_status = 16'h0001;
        strobe();
        chk("R2 chan_en second pattern", 128'(chan_en), 128'(pat2));
    endtask

    task automatic t_bright();
        logic [LW-1:0] w;
        w = make_levels(69);
        set_mode(1'b1);
        for (int i = LW-1; i >= 0; i--) begin
            send_bit(w[i]);
            if (i == 60) chk("R8 chan_level unchanged mid-shift", 128'(chan_level), 128'h0);
        end
        chk("R9 first bit out after 112 shifts", 128'(ser_out), 128'(w[111]));
        strobe();
        chk("R3 chan_level after brightness load", 128'(chan_level), 128'(w));
        chk("R4 chan_en untouched by brightness strobe", 128'(chan_en), 128'h0F3C);
        chk("R6 no status load in brightness mode", 128'(ser_out), 128'(w[111]));
        send_bit(1'b0);
        chk("R9 next bit after one more shift", 128'(ser_out), 128'(w[110]));
        set_mode(1'b0);
        chk("R5 ser_out follows on/off chain", 128'(ser_out), 128'h0);
        set_mode(1'b1);
        chk("R5 ser_out follows brightness chain", 128'(ser_out), 128'(w[110]));
    endtask

    task automatic t_strobe_high_shift();
        logic [NCH-1:0] st2;
        logic [LW-1:0]  w;
        st2 = 16'hE691;
        w = make_levels(69);
        set_mode(1'b0);
        open_status = st2;
        ser_lat = 1'b1;
        wait_clk(8);
        for (int k = 0; k < 5; k++) send_bit(1'b0);
        ser_lat = 1'b0;
        wait_clk(6);
        chk("R7 on/off chain held during strobe-high pulses", 128'(ser_out), 128'(st2[15]));
        open_status = 16'h0000;
        strobe();
        chk("R7 latched value is the unshifted status", 128'(chan_en), 128'(st2));
        chk("R4 chan_level kept across on/off strobes", 128'(chan_level), 128'(w));
        set_mode(1'b1);
        ser_lat = 1'b1;
        wait_clk(8);
        for (int k = 0; k < 3; k++) send_bit(1'b1);
        ser_lat = 1'b0;
        wait_clk(6);
        chk("R7 brightness chain held during strobe-high pulses", 128'(ser_out), 128'(w[110]));
    endtask

    initial begin
        rst_n = 1'b0;
        sel_bright = 1'b0;
        ser_in = 1'b0;
        ser_clk = 1'b0;
        ser_lat = 1'b0;
        open_status = '0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_onoff();
        t_bright();
        t_strobe_high_shift();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule